// File: doc/BRIEF.md
# Control-Transfer Resolver

This block works out where execution goes next for the base 32-bit control-flow and PC-relative instruction group. It covers the direct jump-and-link, the register-indirect jump-and-link, add-upper-immediate-to-PC, and the six conditional branches. Each instruction word arrives with its own address. The block splits the word into its fields and drives the two source-register indices to an external register file. It takes the operand values back in the same cycle and reassembles the scattered immediate bit fields. From these it forms the next program counter and the optional destination write.

Inputs are sampled on a valid strobe. One clock later the block presents the following as registered results, together with a matching valid flag:

- the next PC
- the destination index, data and write enable
- an illegal flag

The register width is a parameter that may be 32 or 64. At 64, every immediate, including the 32-bit upper immediate, is sign-extended to the full width before it is added. A second parameter chooses how the branch comparator is built.

Top module: `ctr_resolve`

## Requirements
- R1: For the direct jump (opcode 1101111), the offset is assembled with instruction bit 31 as offset bit 20, bits 19:12 as offset bits 19:12, bit 20 as offset bit 11, and bits 30:21 as offset bits 10:1. Offset bit 0 is zero and the offset is sign-extended from bit 20. The next PC is address plus offset. The destination (bits 11:7) receives address+4.
- R2: For the indirect jump (opcode 1100111), the 12-bit immediate in bits 31:20 is sign-extended and added to the first operand (index in bits 19:15). Bit 0 of the sum is forced to zero to form the next PC. The destination receives address+4.
- R3: For add-upper-immediate-to-PC (opcode 0010111), bits 31:12 become bits 31:12 of a value with zero low bits. That value is added to the address and written to the destination, and the next PC is address+4.
- R4: For a branch (opcode 1100011), the offset is assembled with instruction bit 31 as offset bit 12, bit 7 as offset bit 11, bits 30:25 as offset bits 10:5, and bits 11:8 as offset bits 4:1. The offset is sign-extended from bit 12, and a taken branch goes to address plus offset.
- R5: Branch condition field bits 14:12 select among six conditions: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. A false condition gives next PC address+4. A branch never writes a register.
- R6: An operand whose index is 0 is treated as zero whatever value the register file returns.
- R7: When the destination index is 0, the write enable stays low.
- R8: The word is illegal if its opcode is none of the four listed, or if it is a branch with condition 010 or 011. An illegal word raises the illegal flag, keeps the write enable low, and gives next PC equal to the instruction address.
- R9: Results appear on the clock edge after the one that samples a high valid input, with the output valid high. A cycle with valid input low yields output valid, write enable and illegal all low on the next edge.
- R10: While reset is active, output valid, write enable and illegal are low.
- R11: The operand index outputs follow instruction bits 19:15 and 24:20 combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | Instruction word and address are present |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | Address of the instruction |
| rs1_idx | output | 5 | First operand index to the register file |
| rs2_idx | output | 5 | Second operand index to the register file |
| rs1_data | input | XLEN | First operand value from the register file |
| rs2_data | input | XLEN | Second operand value from the register file |
| out_valid | output | 1 | Registered results are valid |
| next_pc | output | XLEN | Resolved next program counter |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | XLEN | Destination write data |
| rd_wen | output | 1 | Destination write enable |
| illegal | output | 1 | Instruction word rejected |

## Verification
The bench aims at the immediate-bit shuffles with offsets that set only one scrambled field. A decoder that misplaces offset bit 11 or the sign bit jumps to a wrong but plausible address. It uses operands that differ only in sign to separate the signed and unsigned conditions. A comparator built the wrong way would take a branch it should skip. It drives garbage on the operand bus for index 0 and targets index 0 with writes, so a block that trusts the register file for x0 or writes it would be caught. It also drives odd indirect sums to catch a missing bit-0 clear, and the two reserved branch conditions, which a loose decoder would resolve as real branches.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

   localparam logic [6:0] OPC_JAL    = 7'b1101111;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;
   localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;

   localparam int unsigned IDX_W = 5;
   localparam int unsigned INSN_W = 32;

   typedef enum logic [2:0] {
      K_JAL    = 3'd0,
      K_JALR   = 3'd1,
      K_AUIPC  = 3'd2,
      K_BRANCH = 3'd3,
      K_NONE   = 3'd4
   } ctr_kind_e;

   typedef enum logic [2:0] {
      C_EQ  = 3'b000,
      C_NE  = 3'b001,
      C_RS2 = 3'b010,
      C_RS3 = 3'b011,
      C_LT  = 3'b100,
      C_GE  = 3'b101,
      C_LTU = 3'b110,
      C_GEU = 3'b111
   } ctr_cond_e;

   function automatic logic cond_defined(input logic [2:0] c);
      return (c != C_RS2) && (c != C_RS3);
   endfunction

endpackage

// File: rtl/ctr_decode.sv
module ctr_decode
   import ctr_pkg::*;
(
   input  logic [INSN_W-1:0] instr,
   output ctr_kind_e         kind,
   output logic              legal,
   output logic [2:0]        cond,
   output logic [IDX_W-1:0]  rd,
   output logic [IDX_W-1:0]  rs1,
   output logic [IDX_W-1:0]  rs2,
   output logic              wants_rd
);

   logic [6:0] opc;

   assign opc  = instr[6:0];
   assign rd   = instr[11:7];
   assign cond = instr[14:12];
   assign rs1  = instr[19:15];
   assign rs2  = instr[24:20];

   always_comb begin
      kind  = K_NONE;
      legal = 1'b0;
      unique case (opc)
         OPC_JAL: begin
            kind  = K_JAL;
            legal = 1'b1;
         end
         OPC_JALR: begin
            kind  = K_JALR;
            legal = 1'b1;
         end
         OPC_AUIPC: begin
            kind  = K_AUIPC;
            legal = 1'b1;
         end
         OPC_BRANCH: begin
            kind  = K_BRANCH;
            legal = cond_defined(cond);
         end
         default: begin
            kind  = K_NONE;
            legal = 1'b0;
         end
      endcase
   end

   assign wants_rd = legal && (kind != K_BRANCH) && (rd != '0);

endmodule

// File: rtl/ctr_imm_unpack.sv
module ctr_imm_unpack
   import ctr_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [INSN_W-1:0] instr,
   output logic [XLEN-1:0]   imm_i,
   output logic [XLEN-1:0]   imm_b,
   output logic [XLEN-1:0]   imm_j,
   output logic [XLEN-1:0]   imm_u
);

   localparam int unsigned I_W = 12;
   localparam int unsigned B_W = 13;
   localparam int unsigned J_W = 21;
   localparam int unsigned U_W = 32;

   logic [I_W-1:0] raw_i;
   logic [B_W-1:0] raw_b;
   logic [J_W-1:0] raw_j;
   logic [U_W-1:0] raw_u;

   assign raw_i = instr[31:20];
   assign raw_b = {instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
   assign raw_j = {instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
   assign raw_u = {instr[31:12], 12'h000};

   assign imm_i = {{(XLEN-I_W){raw_i[I_W-1]}}, raw_i};
   assign imm_b = {{(XLEN-B_W){raw_b[B_W-1]}}, raw_b};
   assign imm_j = {{(XLEN-J_W){raw_j[J_W-1]}}, raw_j};

   generate
      if (XLEN > U_W) begin : g_u_ext
         assign imm_u = {{(XLEN-U_W){raw_u[U_W-1]}}, raw_u};
      end else begin : g_u_plain
         assign imm_u = raw_u;
      end
   endgenerate

endmodule

// File: rtl/ctr_cond_eval.sv
module ctr_cond_eval
   import ctr_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter bit          SHARED_SUB = 1'b1
) (
   input  logic [XLEN-1:0] op_a,
   input  logic [XLEN-1:0] op_b,
   input  logic [2:0]      cond,
   output logic            taken
);

   localparam int unsigned MSB = XLEN - 1;

   logic is_eq;
   logic lt_s;
   logic lt_u;

   assign is_eq = (op_a == op_b);

   generate
      if (SHARED_SUB) begin : g_shared
         logic [XLEN:0] diff;
         assign diff = {1'b0, op_a} - {1'b0, op_b};
         assign lt_u = diff[XLEN];
         assign lt_s = (op_a[MSB] != op_b[MSB]) ? op_a[MSB] : diff[XLEN];
      end else begin : g_split
         assign lt_u = (op_a < op_b);
         assign lt_s = ($signed(op_a) < $signed(op_b));
      end
   endgenerate

   always_comb begin
      unique case (ctr_cond_e'(cond))
         C_EQ:    taken = is_eq;
         C_NE:    taken = !is_eq;
         C_LT:    taken = lt_s;
         C_GE:    taken = !lt_s;
         C_LTU:   taken = lt_u;
         C_GEU:   taken = !lt_u;
         default: taken = 1'b0;
      endcase
   end

endmodule

// File: rtl/ctr_resolve.sv
module ctr_resolve
   import ctr_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter bit          SHARED_SUB = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [31:0]      instr,
   input  logic [XLEN-1:0]  pc,
   output logic [4:0]       rs1_idx,
   output logic [4:0]       rs2_idx,
   input  logic [XLEN-1:0]  rs1_data,
   input  logic [XLEN-1:0]  rs2_data,
   output logic             out_valid,
   output logic [XLEN-1:0]  next_pc,
   output logic [4:0]       rd_idx,
   output logic [XLEN-1:0]  rd_data,
   output logic             rd_wen,
   output logic             illegal
);

   localparam logic [XLEN-1:0] STEP = XLEN'(4);

   generate
      if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
         $error("ctr_resolve: XLEN must be 32 or 64");
      end
      if (IDX_W != 5) begin : g_bad_idx
         $error("ctr_resolve: index width must be 5");
      end
   endgenerate

   ctr_kind_e        kind;
   logic             legal;
   logic [2:0]       cond;
   logic [IDX_W-1:0] dec_rd;
   logic [IDX_W-1:0] dec_rs1;
   logic [IDX_W-1:0] dec_rs2;
   logic             wants_rd;

   ctr_decode u_decode (
      .instr    (instr),
      .kind     (kind),
      .legal    (legal),
      .cond     (cond),
      .rd       (dec_rd),
      .rs1      (dec_rs1),
      .rs2      (dec_rs2),
      .wants_rd (wants_rd)
   );

   assign rs1_idx = dec_rs1;
   assign rs2_idx = dec_rs2;

   logic [XLEN-1:0] imm_i;
   logic [XLEN-1:0] imm_b;
   logic [XLEN-1:0] imm_j;
   logic [XLEN-1:0] imm_u;

   ctr_imm_unpack #(.XLEN(XLEN)) u_imm (
      .instr (instr),
      .imm_i (imm_i),
      .imm_b (imm_b),
      .imm_j (imm_j),
      .imm_u (imm_u)
   );

   logic [XLEN-1:0] op_a;
   logic [XLEN-1:0] op_b;

   assign op_a = (dec_rs1 == '0) ? '0 : rs1_data;
   assign op_b = (dec_rs2 == '0) ? '0 : rs2_data;

   logic taken;

   ctr_cond_eval #(.XLEN(XLEN), .SHARED_SUB(SHARED_SUB)) u_cond (
      .op_a  (op_a),
      .op_b  (op_b),
      .cond  (cond),
      .taken (taken)
   );

   logic [XLEN-1:0] rel_off;
   logic [XLEN-1:0] pc_rel;
   logic [XLEN-1:0] pc_seq;
   logic [XLEN-1:0] ind_sum;
   logic [XLEN-1:0] ind_tgt;

   always_comb begin
      unique case (kind)
         K_JAL:   rel_off = imm_j;
         K_AUIPC: rel_off = imm_u;
         default: rel_off = imm_b;
      endcase
   end

   assign pc_rel  = pc + rel_off;
   assign pc_seq  = pc + STEP;
   assign ind_sum = op_a + imm_i;
   assign ind_tgt = {ind_sum[XLEN-1:1], 1'b0};

   logic [XLEN-1:0] npc_c;
   logic [XLEN-1:0] wdata_c;

   always_comb begin
      npc_c = pc;
      if (legal) begin
         unique case (kind)
            K_JAL:    npc_c = pc_rel;
            K_JALR:   npc_c = ind_tgt;
            K_AUIPC:  npc_c = pc_seq;
            K_BRANCH: npc_c = taken ? pc_rel : pc_seq;
            default:  npc_c = pc;
         endcase
      end
   end

   assign wdata_c = (kind == K_AUIPC) ? pc_rel : pc_seq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         next_pc   <= '0;
         rd_idx    <= '0;
         rd_data   <= '0;
         rd_wen    <= 1'b0;
         illegal   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         next_pc   <= npc_c;
         rd_idx    <= dec_rd;
         rd_data   <= wdata_c;
         rd_wen    <= in_valid && wants_rd;
         illegal   <= in_valid && !legal;
      end
   end

endmodule

// File: rtl/ctr_resolve_chk.sv
module ctr_resolve_chk
   import ctr_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [31:0]     instr,
   input logic [XLEN-1:0] pc,
   input logic            out_valid,
   input logic [XLEN-1:0] next_pc,
   input logic [4:0]      rd_idx,
   input logic            rd_wen,
   input logic            illegal
);

   logic known_opc;
   assign known_opc = (instr[6:0] == OPC_JAL) || (instr[6:0] == OPC_JALR) ||
                      (instr[6:0] == OPC_AUIPC) || (instr[6:0] == OPC_BRANCH);

   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R9

   AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !rd_wen && !illegal)); // R9

   AST_NO_WRITE_X0: assert property (@(posedge clk) disable iff (!rst_n)
      rd_wen |-> (rd_idx != 5'd0)); // R7

   AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !rd_wen); // R8

   AST_UNKNOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !known_opc) |=> (illegal && next_pc == $past(pc))); // R8

   AST_INDIRECT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[6:0] == OPC_JALR) |=> (next_pc[0] == 1'b0)); // R2

   AST_UPPER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[6:0] == OPC_AUIPC) |=> (next_pc == $past(pc) + XLEN'(4))); // R3

endmodule

bind ctr_resolve ctr_resolve_chk #(.XLEN(XLEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .instr     (instr),
   .pc        (pc),
   .out_valid (out_valid),
   .next_pc   (next_pc),
   .rd_idx    (rd_idx),
   .rd_wen    (rd_wen),
   .illegal   (illegal)
);

// File: tb/ctr_resolve_tb.sv
`timescale 1ns/1ps
module ctr_resolve_tb_top;

   localparam int unsigned XLEN = 32;
   localparam int NVEC = 21;

   localparam logic [2:0] KJ = 3'd0;
   localparam logic [2:0] KI = 3'd1;
   localparam logic [2:0] KU = 3'd2;
   localparam logic [2:0] KB = 3'd3;
   localparam logic [2:0] KR = 3'd4;

   typedef struct packed {
      logic [3:0]  req;
      logic [2:0]  kind;
      logic [2:0]  f3;
      logic [4:0]  rd;
      logic [4:0]  rs1;
      logic [4:0]  rs2;
      logic [31:0] imm;
      logic [31:0] pc;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] exp_pc;
      logic        exp_wen;
      logic [31:0] exp_wd;
      logic        exp_ill;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      // R1 positive offset exercising bit 11
      '{4'd1, KJ, 3'd0, 5'd1, 5'd0, 5'd0, 32'h00000800, 32'h00001000, 32'h0, 32'h0, 32'h00001800, 1'b1, 32'h00001004, 1'b0},
      // R1 negative offset
      '{4'd1, KJ, 3'd0, 5'd5, 5'd0, 5'd0, 32'hFFFFFFFC, 32'h00002000, 32'h0, 32'h0, 32'h00001FFC, 1'b1, 32'h00002004, 1'b0},
      // R7 jump with destination x0
      '{4'd7, KJ, 3'd0, 5'd0, 5'd0, 5'd0, 32'h0007FFFE, 32'h00000000, 32'h0, 32'h0, 32'h0007FFFE, 1'b0, 32'h0, 1'b0},
      // R2 odd sum, bit 0 cleared
      '{4'd2, KI, 3'd0, 5'd2, 5'd3, 5'd0, 32'h00000007, 32'h00000400, 32'h00000100, 32'h0, 32'h00000106, 1'b1, 32'h00000404, 1'b0},
      // R2 negative immediate
      '{4'd2, KI, 3'd0, 5'd1, 5'd4, 5'd0, 32'hFFFFFFFF, 32'h00000010, 32'h00002001, 32'h0, 32'h00002000, 1'b1, 32'h00000014, 1'b0},
      // R6 base index 0 with garbage on the bus
      '{4'd6, KI, 3'd0, 5'd3, 5'd0, 5'd0, 32'h00000020, 32'h00000050, 32'hDEAD0000, 32'h0, 32'h00000020, 1'b1, 32'h00000054, 1'b0},
      // R3 upper immediate
      '{4'd3, KU, 3'd0, 5'd7, 5'd0, 5'd0, 32'h12345000, 32'h00000100, 32'h0, 32'h0, 32'h00000104, 1'b1, 32'h12345100, 1'b0},
      // R7 upper immediate to x0
      '{4'd7, KU, 3'd0, 5'd0, 5'd0, 5'd0, 32'hFFFFF000, 32'h00003000, 32'h0, 32'h0, 32'h00003004, 1'b0, 32'h0, 1'b0},
      // R5 equal, taken
      '{4'd5, KB, 3'b000, 5'd0, 5'd1, 5'd2, 32'h00000010, 32'h00001000, 32'd5, 32'd5, 32'h00001010, 1'b0, 32'h0, 1'b0},
      // R5 equal, not taken
      '{4'd5, KB, 3'b000, 5'd0, 5'd1, 5'd2, 32'h00000010, 32'h00001000, 32'd5, 32'd6, 32'h00001004, 1'b0, 32'h0, 1'b0},
      // R4 not equal, offset sign bit 12
      '{4'd4, KB, 3'b001, 5'd0, 5'd1, 5'd2, 32'hFFFFF000, 32'h00001000, 32'd5, 32'd6, 32'h00000000, 1'b0, 32'h0, 1'b0},
      // R5 signed less-than, -1 < 1
      '{4'd5, KB, 3'b100, 5'd0, 5'd1, 5'd2, 32'h00000020, 32'h00001000, 32'hFFFFFFFF, 32'd1, 32'h00001020, 1'b0, 32'h0, 1'b0},
      // R5 unsigned less-than, same operands, not taken
      '{4'd5, KB, 3'b110, 5'd0, 5'd1, 5'd2, 32'h00000020, 32'h00001000, 32'hFFFFFFFF, 32'd1, 32'h00001004, 1'b0, 32'h0, 1'b0},
      // R4 signed greater-or-equal, offset bit 11
      '{4'd4, KB, 3'b101, 5'd0, 5'd1, 5'd2, 32'h00000800, 32'h00001000, 32'd1, 32'hFFFFFFFF, 32'h00001800, 1'b0, 32'h0, 1'b0},
      // R5 unsigned greater-or-equal, not taken
      '{4'd5, KB, 3'b111, 5'd0, 5'd1, 5'd2, 32'h00000800, 32'h00001000, 32'd1, 32'hFFFFFFFF, 32'h00001004, 1'b0, 32'h0, 1'b0},
      // R4 offset bits 4:1, equal operands under greater-or-equal
      '{4'd4, KB, 3'b101, 5'd0, 5'd1, 5'd2, 32'h0000001E, 32'h00001000, 32'd7, 32'd7, 32'h0000101E, 1'b0, 32'h0, 1'b0},
      // R4 offset bits 10:5, unsigned greater-or-equal taken
      '{4'd4, KB, 3'b111, 5'd0, 5'd1, 5'd2, 32'h000007E0, 32'h00001000, 32'h80000000, 32'h7FFFFFFF, 32'h000017E0, 1'b0, 32'h0, 1'b0},
      // R6 first operand index 0 reads zero
      '{4'd6, KB, 3'b100, 5'd0, 5'd0, 5'd2, 32'h00000040, 32'h00001000, 32'hFFFFFFFF, 32'd1, 32'h00001040, 1'b0, 32'h0, 1'b0},
      // R8 reserved condition 010
      '{4'd8, KB, 3'b010, 5'd0, 5'd1, 5'd2, 32'h00000010, 32'h00001000, 32'd5, 32'd5, 32'h00001000, 1'b0, 32'h0, 1'b1},
      // R8 reserved condition 011
      '{4'd8, KB, 3'b011, 5'd0, 5'd1, 5'd2, 32'h00000010, 32'h00001000, 32'd5, 32'd6, 32'h00001000, 1'b0, 32'h0, 1'b1},
      // R8 unknown opcode
      '{4'd8, KR, 3'd0, 5'd0, 5'd0, 5'd0, 32'h00000033, 32'h00001000, 32'h0, 32'h0, 32'h00001000, 1'b0, 32'h0, 1'b1}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [31:0]     instr = 32'h0;
   logic [XLEN-1:0] pc = '0;
   logic [4:0]      rs1_idx;
   logic [4:0]      rs2_idx;
   logic [XLEN-1:0] rs1_data = '0;
   logic [XLEN-1:0] rs2_data = '0;
   logic            out_valid;
   logic [XLEN-1:0] next_pc;
   logic [4:0]      rd_idx;
   logic [XLEN-1:0] rd_data;
   logic            rd_wen;
   logic            illegal;

   int n_checks = 0;
   int n_errors = 0;
   bit timed_out = 1'b0;

   always #2 clk = ~clk;

   ctr_resolve #(.XLEN(XLEN)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .instr     (instr),
      .pc        (pc),
      .rs1_idx   (rs1_idx),
      .rs2_idx   (rs2_idx),
      .rs1_data  (rs1_data),
      .rs2_data  (rs2_data),
      .out_valid (out_valid),
      .next_pc   (next_pc),
      .rd_idx    (rd_idx),
      .rd_data   (rd_data),
      .rd_wen    (rd_wen),
      .illegal   (illegal)
   );

   function automatic logic [31:0] enc(input vec_t v);
      case (v.kind)
         KJ: enc = {v.imm[20], v.imm[10:1], v.imm[11], v.imm[19:12], v.rd, 7'b1101111};
         KI: enc = {v.imm[11:0], v.rs1, 3'b000, v.rd, 7'b1100111};
         KU: enc = {v.imm[31:12], v.rd, 7'b0010111};
         KB: enc = {v.imm[12], v.imm[10:5], v.rs2, v.rs1, v.f3, v.imm[4:1], v.imm[11], 7'b1100011};
         default: enc = v.imm;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_all();
      // R10: outputs stay low while reset holds, even with a valid jump driven
      @(negedge clk);
      in_valid = 1'b1;
      instr    = {1'b0, 10'h001, 1'b0, 8'h00, 5'd1, 7'b1101111};
      pc       = 32'h100;
      repeat (3) @(negedge clk);
      check("R10 reset out_valid", {31'b0, out_valid}, 32'd0);
      check("R10 reset rd_wen", {31'b0, rd_wen}, 32'd0);
      check("R10 reset illegal", {31'b0, illegal}, 32'd0);

      // R9: valid low gives quiet outputs on the next edge
      in_valid = 1'b0;
      rst_n    = 1'b1;
      @(negedge clk);
      check("R9 idle out_valid", {31'b0, out_valid}, 32'd0);
      check("R9 idle rd_wen", {31'b0, rd_wen}, 32'd0);
      instr = 32'h00000033;
      @(negedge clk);
      check("R9 idle illegal", {31'b0, illegal}, 32'd0);

      for (int i = 0; i < NVEC; i++) begin
         vec_t v;
         v        = VECS[i];
         instr    = enc(v);
         pc       = v.pc;
         rs1_data = v.a;
         rs2_data = v.b;
         in_valid = 1'b1;
         #1;
         if (v.kind == KB) begin
            check($sformatf("R11 vec%0d rs1_idx", i), {27'b0, rs1_idx}, {27'b0, v.rs1});
            check($sformatf("R11 vec%0d rs2_idx", i), {27'b0, rs2_idx}, {27'b0, v.rs2});
         end
         @(negedge clk);
         check($sformatf("R9 vec%0d out_valid", i), {31'b0, out_valid}, 32'd1);
         check($sformatf("R%0d vec%0d next_pc", v.req, i), next_pc, v.exp_pc);
         check($sformatf("R%0d vec%0d rd_wen", v.req, i), {31'b0, rd_wen}, {31'b0, v.exp_wen});
         check($sformatf("R%0d vec%0d illegal", v.req, i), {31'b0, illegal}, {31'b0, v.exp_ill});
         if (v.exp_wen) begin
            check($sformatf("R%0d vec%0d rd_idx", v.req, i), {27'b0, rd_idx}, {27'b0, v.rd});
            check($sformatf("R%0d vec%0d rd_data", v.req, i), rd_data, v.exp_wd);
         end
      end

      // R9: valid dropped after a stream of results
      in_valid = 1'b0;
      @(negedge clk);
      check("R9 drop out_valid", {31'b0, out_valid}, 32'd0);
      check("R9 drop illegal", {31'b0, illegal}, 32'd0);

      // R10: reset mid-run clears a pending write result
      instr    = {12'h004, 5'd3, 3'b000, 5'd9, 7'b1100111};
      rs1_data = 32'h40;
      in_valid = 1'b1;
      @(negedge clk);
      check("R2 pre-reset rd_wen", {31'b0, rd_wen}, 32'd1);
      check("R2 pre-reset next_pc", next_pc, 32'h44);
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 mid reset out_valid", {31'b0, out_valid}, 32'd0);
      check("R10 mid reset rd_wen", {31'b0, rd_wen}, 32'd0);
      in_valid = 1'b0;
      rst_n    = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=expired expected=done");
      end
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule